// File: doc/BRIEF.md
# Cross-Bus Snoop Filter Controller

This block sits between two processor buses and shared memory and decides, for every memory transaction, whether the opposite bus must be snooped. It keeps one presence directory per bus. Each directory records the line addresses currently held in the caches of the processors on its own bus. It learns these addresses from the line fills and line evictions that its bus reports.

When a transaction arrives from one bus, only the directory of the other bus is consulted. On a miss, snooping stays on the requesting bus and the request is released to memory at once. On a hit, the block asks for a snoop of the remote bus. The memory access is released only after that snoop is reported complete, so that memory sees the most recent copy of the line.

Each directory is set-associative. When a fill lands in a set that is already full, an entry is replaced in round-robin order. The caches on that bus are then told to drop the replaced line through a back-invalidate output. Both buses may issue transactions in the same cycle, and each one is checked independently.

Top module: `xbus_snoop_filter`

## Requirements
- R1: After synchronous reset every output is low and both directories are empty, so the first transaction from either bus misses.
- R2: A transaction from bus b whose line is absent from the directory of bus 1-b raises mem_go_o[b] for one cycle, in the cycle after the transaction, with mem_line_o[b] equal to its line and no snoop request.
- R3: A transaction from bus b whose line is present in the directory of bus 1-b raises rsnoop_req_o[b] for one cycle, in the cycle after the transaction, with rsnoop_line_o[b] equal to its line and no mem_go_o[b].
- R4: After a remote snoop request for bus b, mem_go_o[b] rises in the cycle after snoop_done_i[b] is seen, carrying the snooped line. A snoop_done_i[b] that arrives while no snoop is pending for bus b has no effect.
- R5: While a snoop for bus b is pending, further transactions from bus b are dropped: they produce no output, either then or after the snoop completes.
- R6: A bus's own directory is never consulted for its own transactions, so a line filled by bus b does not cause a remote snoop for a transaction from bus b.
- R7: A drop notice from bus b removes the line from the directory of bus b. A drop notice for a line not present leaves the directory unchanged.
- R8: A line address splits into a set index in its low log2(SETS) bits (6 by default) and a tag in the remaining upper bits. Each set holds WAYS (4) entries. A fill to a set with a free entry takes the lowest free way. A fill of a line already present changes nothing and raises no back-invalidate. A fill of a new line into a full set replaces the way named by that set's round-robin pointer, which starts at way 0 and advances by one on each replacement. It also raises binv_valid_o[b] in the cycle after the fill, with binv_line_o[b] equal to the replaced line's full address.
- R9: When an update to a directory and a lookup into the same set of that directory occur in the same cycle, the lookup sees the updated contents: a same-cycle fill makes it hit and a same-cycle drop makes it miss.
- R10: Transactions from both buses in the same cycle are each checked against the opposite directory in parallel, and each bus receives its own result in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid_i | input | 2 | Memory transaction present, one bit per bus |
| txn_line_i | input | 2 x LINE_W | Line address of each bus's transaction |
| fill_valid_i | input | 2 | A cache on this bus filled a line |
| fill_line_i | input | 2 x LINE_W | Filled line address (a fill wins over a drop in the same cycle) |
| drop_valid_i | input | 2 | A cache on this bus evicted a line |
| drop_line_i | input | 2 x LINE_W | Evicted line address |
| snoop_done_i | input | 2 | Remote snoop for this bus's pending transaction has finished |
| rsnoop_req_o | output | 2 | Request a snoop of the opposite bus for this bus's transaction |
| rsnoop_line_o | output | 2 x LINE_W | Line to snoop on the opposite bus |
| mem_go_o | output | 2 | Transaction may proceed to memory |
| mem_line_o | output | 2 x LINE_W | Line released to memory |
| binv_valid_o | output | 2 | Back-invalidate request to the caches on this bus |
| binv_line_o | output | 2 x LINE_W | Line to be invalidated |

## Verification
Several properties are checked on every cycle. A snoop request and a memory release never occur together for the same bus. A release that follows a snoop is always preceded by a completion. Every snoop request or direct release traces back to a transaction made while the bus was idle. Every back-invalidate follows a fill on the same bus. Whether a given line should hit or miss depends on directory contents, and the assertions cannot judge that. Hit and miss outcomes are shown only by the bench's scenarios. Those scenarios cover the round-robin victim order, the ignored drops and refills, and same-cycle update forwarding.

// File: rtl/sf_pkg.sv
package sf_pkg;
  // Per-bus transaction sequencing state
  typedef enum logic {
    TS_IDLE = 1'b0,
    TS_WAIT = 1'b1
  } txn_state_e;
endpackage

// File: rtl/sf_filter.sv
// Set-associative presence directory for the caches of one bus.
// Update port: fills/drops from the owning bus. Lookup port: transactions
// from the opposite bus, answered combinationally with update forwarding.
module sf_filter #(
  parameter int LINE_W = 20,
  parameter int SETS   = 64,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              drop_i,
  input  logic [LINE_W-1:0] drop_line_i,
  input  logic [LINE_W-1:0] look_line_i,
  output logic              hit_o,
  output logic              binv_o,
  output logic [LINE_W-1:0] binv_line_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LINE_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int ROW_W = WAYS * TAG_W;

  logic [ROW_W-1:0] tag_mem [SETS];
  logic [WAYS-1:0]  vld_q   [SETS];
  logic [WAY_W-1:0] rr_q    [SETS];

  logic [LINE_W-1:0] u_line;
  logic [IDX_W-1:0]  u_idx, l_idx;
  logic [TAG_W-1:0]  u_tag, l_tag;
  logic [ROW_W-1:0]  row_tag, nxt_tag, l_row_tag;
  logic [WAYS-1:0]   row_vld, nxt_vld, l_row_vld;
  logic [WAY_W-1:0]  row_rr, nxt_rr, free_way;
  logic [WAYS-1:0]   u_match, l_match;
  logic              row_we, do_binv;
  logic [LINE_W-1:0] victim_line;

  assign u_line  = fill_i ? fill_line_i : drop_line_i;
  assign u_idx   = u_line[IDX_W-1:0];
  assign u_tag   = u_line[LINE_W-1:IDX_W];
  assign l_idx   = look_line_i[IDX_W-1:0];
  assign l_tag   = look_line_i[LINE_W-1:IDX_W];
  assign row_tag = tag_mem[u_idx];
  assign row_vld = vld_q[u_idx];
  assign row_rr  = rr_q[u_idx];

  // Per-way compare for update and lookup ports
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign u_match[w] = row_vld[w] && (row_tag[w*TAG_W +: TAG_W] == u_tag);
    assign l_match[w] = l_row_vld[w] && (l_row_tag[w*TAG_W +: TAG_W] == l_tag);
  end

  // Lowest free way
  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!row_vld[w]) free_way = WAY_W'(w);
    end
  end

  // Next contents of the updated set
  always_comb begin
    nxt_tag     = row_tag;
    nxt_vld     = row_vld;
    nxt_rr      = row_rr;
    row_we      = 1'b0;
    do_binv     = 1'b0;
    victim_line = '0;
    if (fill_i) begin
      if (|u_match) begin
        row_we = 1'b0;
      end else if (!(&row_vld)) begin
        nxt_tag[free_way*TAG_W +: TAG_W] = u_tag;
        nxt_vld[free_way] = 1'b1;
        row_we = 1'b1;
      end else begin
        do_binv     = 1'b1;
        victim_line = {row_tag[row_rr*TAG_W +: TAG_W], u_idx};
        nxt_tag[row_rr*TAG_W +: TAG_W] = u_tag;
        nxt_rr = (row_rr == WAY_W'(WAYS - 1)) ? '0 : row_rr + 1'b1;
        row_we = 1'b1;
      end
    end else if (drop_i && (|u_match)) begin
      nxt_vld = row_vld & ~u_match;
      row_we  = 1'b1;
    end
  end

  // Lookup reads the post-update row when it targets the set being written
  assign l_row_tag = (row_we && (l_idx == u_idx)) ? nxt_tag : tag_mem[l_idx];
  assign l_row_vld = (row_we && (l_idx == u_idx)) ? nxt_vld : vld_q[l_idx];
  assign hit_o     = |l_match;

  // Tag storage: no reset, one row written per cycle
  always_ff @(posedge clk) begin
    if (row_we) tag_mem[u_idx] <= nxt_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (row_we) begin
      vld_q[u_idx] <= nxt_vld;
      rr_q[u_idx]  <= nxt_rr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      binv_o      <= 1'b0;
      binv_line_o <= '0;
    end else begin
      binv_o      <= do_binv;
      binv_line_o <= victim_line;
    end
  end
endmodule

// File: rtl/sf_txn_ctl.sv
// Sequences one bus's transactions: direct release on a remote miss,
// snoop request then release after completion on a remote hit.
module sf_txn_ctl
  import sf_pkg::*;
#(
  parameter int LINE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_i,
  input  logic [LINE_W-1:0] txn_line_i,
  input  logic              rhit_i,
  input  logic              done_i,
  output logic              rsnoop_o,
  output logic [LINE_W-1:0] rsnoop_line_o,
  output logic              go_o,
  output logic [LINE_W-1:0] go_line_o
);
  txn_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= TS_IDLE;
      rsnoop_o      <= 1'b0;
      rsnoop_line_o <= '0;
      go_o          <= 1'b0;
      go_line_o     <= '0;
    end else begin
      rsnoop_o <= 1'b0;
      go_o     <= 1'b0;
      case (state_q)
        TS_IDLE: begin
          if (txn_i) begin
            if (rhit_i) begin
              rsnoop_o      <= 1'b1;
              rsnoop_line_o <= txn_line_i;
              state_q       <= TS_WAIT;
            end else begin
              go_o      <= 1'b1;
              go_line_o <= txn_line_i;
            end
          end
        end
        TS_WAIT: begin
          if (done_i) begin
            go_o      <= 1'b1;
            go_line_o <= rsnoop_line_o;
            state_q   <= TS_IDLE;
          end
        end
        default: state_q <= TS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_snoop_filter.sv
// Two presence directories, each consulted only by the opposite bus.
module xbus_snoop_filter #(
  parameter int LINE_W = 20,
  parameter int SETS   = 64,
  parameter int WAYS   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             txn_valid_i,
  input  logic [1:0][LINE_W-1:0] txn_line_i,
  input  logic [1:0]             fill_valid_i,
  input  logic [1:0][LINE_W-1:0] fill_line_i,
  input  logic [1:0]             drop_valid_i,
  input  logic [1:0][LINE_W-1:0] drop_line_i,
  input  logic [1:0]             snoop_done_i,
  output logic [1:0]             rsnoop_req_o,
  output logic [1:0][LINE_W-1:0] rsnoop_line_o,
  output logic [1:0]             mem_go_o,
  output logic [1:0][LINE_W-1:0] mem_line_o,
  output logic [1:0]             binv_valid_o,
  output logic [1:0][LINE_W-1:0] binv_line_o
);
  // dir_hit[b]: the opposite bus's transaction hits the directory of bus b
  logic [1:0] dir_hit;

  for (genvar b = 0; b < 2; b++) begin : g_bus
    sf_filter #(
      .LINE_W(LINE_W),
      .SETS  (SETS),
      .WAYS  (WAYS)
    ) u_dir (
      .clk        (clk),
      .rst        (rst),
      .fill_i     (fill_valid_i[b]),
      .fill_line_i(fill_line_i[b]),
      .drop_i     (drop_valid_i[b]),
      .drop_line_i(drop_line_i[b]),
      .look_line_i(txn_line_i[1-b]),
      .hit_o      (dir_hit[b]),
      .binv_o     (binv_valid_o[b]),
      .binv_line_o(binv_line_o[b])
    );

    sf_txn_ctl #(
      .LINE_W(LINE_W)
    ) u_ctl (
      .clk          (clk),
      .rst          (rst),
      .txn_i        (txn_valid_i[b]),
      .txn_line_i   (txn_line_i[b]),
      .rhit_i       (dir_hit[1-b]),
      .done_i       (snoop_done_i[b]),
      .rsnoop_o     (rsnoop_req_o[b]),
      .rsnoop_line_o(rsnoop_line_o[b]),
      .go_o         (mem_go_o[b]),
      .go_line_o    (mem_line_o[b])
    );
  end
endmodule

// File: rtl/sf_chk.sv
module sf_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] txn_valid_i,
  input logic [1:0] fill_valid_i,
  input logic [1:0] snoop_done_i,
  input logic [1:0] rsnoop_req_o,
  input logic [1:0] mem_go_o,
  input logic [1:0] binv_valid_o
);
  // Observed pending-snoop state per bus, rebuilt from the ports
  logic [1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (rsnoop_req_o[b])  wait_q[b] <= 1'b1;
        else if (mem_go_o[b]) wait_q[b] <= 1'b0;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_chk
    logic busy;
    logic fresh;
    assign busy  = (wait_q[b] || rsnoop_req_o[b]) && !mem_go_o[b];
    assign fresh = rsnoop_req_o[b] || (mem_go_o[b] && !wait_q[b]);

    // R3
    snoop_xor_go_chk: assert property (@(posedge clk) disable iff (rst)
      !(rsnoop_req_o[b] && mem_go_o[b]));

    // R4
    go_after_done_chk: assert property (@(posedge clk) disable iff (rst)
      (wait_q[b] && mem_go_o[b]) |-> $past(snoop_done_i[b]));

    // R2
    result_needs_txn_chk: assert property (@(posedge clk) disable iff (rst)
      fresh |-> $past(txn_valid_i[b]));

    // R5
    drop_while_wait_chk: assert property (@(posedge clk) disable iff (rst)
      fresh |-> !$past(busy));

    // R8
    binv_needs_fill_chk: assert property (@(posedge clk) disable iff (rst)
      binv_valid_o[b] |-> $past(fill_valid_i[b]));
  end
endmodule

bind xbus_snoop_filter sf_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .txn_valid_i (txn_valid_i),
  .fill_valid_i(fill_valid_i),
  .snoop_done_i(snoop_done_i),
  .rsnoop_req_o(rsnoop_req_o),
  .mem_go_o    (mem_go_o),
  .binv_valid_o(binv_valid_o)
);

// File: tb/xbus_snoop_filter_test.sv
module xbus_snoop_filter_test;
  localparam int LW = 20;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]         txn_v = '0, fill_v = '0, drop_v = '0, done_v = '0;
  logic [1:0][LW-1:0] txn_l = '0, fill_l = '0, drop_l = '0;
  logic [1:0]         rsn, go, binv;
  logic [1:0][LW-1:0] rsn_l, go_l, binv_l;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  xbus_snoop_filter #(.LINE_W(LW), .SETS(64), .WAYS(4)) uut (
    .clk(clk), .rst(rst),
    .txn_valid_i(txn_v), .txn_line_i(txn_l),
    .fill_valid_i(fill_v), .fill_line_i(fill_l),
    .drop_valid_i(drop_v), .drop_line_i(drop_l),
    .snoop_done_i(done_v),
    .rsnoop_req_o(rsn), .rsnoop_line_o(rsn_l),
    .mem_go_o(go), .mem_line_o(go_l),
    .binv_valid_o(binv), .binv_line_o(binv_l)
  );

  function automatic logic [LW-1:0] ln(int tag, int set);
    return LW'((tag << IW) | set);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr();
    txn_v = '0; fill_v = '0; drop_v = '0; done_v = '0;
  endtask

  // Check one bus's result after a transaction
  task automatic expect_res(string req, int b, bit snoop, bit mgo, logic [LW-1:0] line);
    chk({req, " snoop"}, 32'(rsn[b]), 32'(snoop));
    chk({req, " go"}, 32'(go[b]), 32'(mgo));
    if (snoop) chk({req, " snoop line"}, 32'(rsn_l[b]), 32'(line));
    if (mgo)   chk({req, " go line"}, 32'(go_l[b]), 32'(line));
  endtask

  task automatic fill(int b, logic [LW-1:0] a);
    fill_v[b] = 1'b1; fill_l[b] = a; tick(); clr();
  endtask

  task automatic drop(int b, logic [LW-1:0] a);
    drop_v[b] = 1'b1; drop_l[b] = a; tick(); clr();
  endtask

  task automatic txn(int b, logic [LW-1:0] a);
    txn_v[b] = 1'b1; txn_l[b] = a; tick(); clr();
  endtask

  task automatic finish_snoop(string req, int b, logic [LW-1:0] a);
    done_v[b] = 1'b1; tick(); clr();
    expect_res(req, b, 1'b0, 1'b1, a);
  endtask

  task automatic t_reset();
    chk("R1 snoop idle", 32'(rsn), 0);
    chk("R1 go idle", 32'(go), 0);
    chk("R1 binv idle", 32'(binv), 0);
    txn(1, ln(3, 1));
    expect_res("R1 empty dir", 1, 1'b0, 1'b1, ln(3, 1));
  endtask

  task automatic t_miss();
    fill(1, ln(1, 2));
    txn(0, ln(2, 2));
    expect_res("R2 miss other tag", 0, 1'b0, 1'b1, ln(2, 2));
  endtask

  task automatic t_hit();
    txn(0, ln(1, 2));
    expect_res("R3 hit", 0, 1'b1, 1'b0, ln(1, 2));
    tick();
    expect_res("R4 hold until done", 0, 1'b0, 1'b0, '0);
    finish_snoop("R4 release", 0, ln(1, 2));
    done_v[0] = 1'b1; tick(); clr();
    expect_res("R4 stray done", 0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_drop_pending();
    txn(0, ln(1, 2));
    expect_res("R5 hit", 0, 1'b1, 1'b0, ln(1, 2));
    txn(0, ln(7, 2));
    expect_res("R5 dropped", 0, 1'b0, 1'b0, '0);
    finish_snoop("R5 first line", 0, ln(1, 2));
    tick();
    expect_res("R5 not queued", 0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_local();
    fill(0, ln(1, 3));
    txn(0, ln(1, 3));
    expect_res("R6 own dir unused", 0, 1'b0, 1'b1, ln(1, 3));
    txn(1, ln(1, 3));
    expect_res("R6 remote sees it", 1, 1'b1, 1'b0, ln(1, 3));
    finish_snoop("R6 release", 1, ln(1, 3));
  endtask

  task automatic t_evict();
    fill(1, ln(1, 4));
    drop(1, ln(2, 4));
    txn(0, ln(1, 4));
    expect_res("R7 absent drop", 0, 1'b1, 1'b0, ln(1, 4));
    finish_snoop("R7 release", 0, ln(1, 4));
    drop(1, ln(1, 4));
    txn(0, ln(1, 4));
    expect_res("R7 cleared", 0, 1'b0, 1'b1, ln(1, 4));
  endtask

  task automatic t_round_robin();
    for (int t = 1; t <= 4; t++) begin
      fill(1, ln(t, 9));
      chk("R8 free way no binv", 32'(binv[1]), 0);
    end
    fill(1, ln(5, 9));
    chk("R8 first victim", 32'(binv[1]), 1);
    chk("R8 victim way0", 32'(binv_l[1]), 32'(ln(1, 9)));
    txn(0, ln(1, 9));
    expect_res("R8 victim gone", 0, 1'b0, 1'b1, ln(1, 9));
    txn(0, ln(5, 9));
    expect_res("R8 new line", 0, 1'b1, 1'b0, ln(5, 9));
    finish_snoop("R8 release", 0, ln(5, 9));
    fill(1, ln(6, 9));
    chk("R8 second victim", 32'(binv_l[1]), 32'(ln(2, 9)));
    fill(1, ln(3, 9));
    chk("R8 refill no binv", 32'(binv[1]), 0);
    fill(1, ln(7, 9));
    chk("R8 third victim valid", 32'(binv[1]), 1);
    chk("R8 third victim way2", 32'(binv_l[1]), 32'(ln(3, 9)));
    txn(0, ln(4, 9));
    expect_res("R8 untouched way", 0, 1'b1, 1'b0, ln(4, 9));
    finish_snoop("R8 release2", 0, ln(4, 9));
  endtask

  task automatic t_same_cycle();
    fill_v[1] = 1'b1; fill_l[1] = ln(1, 11);
    txn_v[0] = 1'b1; txn_l[0] = ln(1, 11);
    tick(); clr();
    expect_res("R9 fill forwarded", 0, 1'b1, 1'b0, ln(1, 11));
    finish_snoop("R9 release", 0, ln(1, 11));
    drop_v[1] = 1'b1; drop_l[1] = ln(1, 11);
    txn_v[0] = 1'b1; txn_l[0] = ln(1, 11);
    tick(); clr();
    expect_res("R9 drop forwarded", 0, 1'b0, 1'b1, ln(1, 11));
  endtask

  task automatic t_parallel();
    fill_v = 2'b11; fill_l[0] = ln(1, 12); fill_l[1] = ln(2, 12);
    tick(); clr();
    txn_v = 2'b11; txn_l[0] = ln(2, 12); txn_l[1] = ln(1, 12);
    tick(); clr();
    expect_res("R10 bus0 hit", 0, 1'b1, 1'b0, ln(2, 12));
    expect_res("R10 bus1 hit", 1, 1'b1, 1'b0, ln(1, 12));
    done_v = 2'b11; tick(); clr();
    expect_res("R10 bus0 go", 0, 1'b0, 1'b1, ln(2, 12));
    expect_res("R10 bus1 go", 1, 1'b0, 1'b1, ln(1, 12));
    txn_v = 2'b11; txn_l[0] = ln(2, 12); txn_l[1] = ln(5, 12);
    tick(); clr();
    expect_res("R10 mixed hit", 0, 1'b1, 1'b0, ln(2, 12));
    expect_res("R10 mixed miss", 1, 1'b0, 1'b1, ln(5, 12));
    finish_snoop("R10 release", 0, ln(2, 12));
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_miss();
    t_hit();
    t_drop_pending();
    t_local();
    t_evict();
    t_round_robin();
    t_same_cycle();
    t_parallel();
    tick();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule